// File: doc/BRIEF.md
# Two-Stage Half-Band Decimate-by-Four Filter

This block sits at the head of a FIR decimation chain. It takes signed samples from an upstream sinc decimator. The samples arrive with a one-cycle valid strobe, at any spacing. The block runs them through two linear-phase half-band low-pass sections in series. Each section halves the sample rate, so the output stream carries one sample for every four accepted inputs, marked by its own one-cycle strobe.

Each section has a fixed, symmetric integer coefficient set. It folds mirrored delay-line taps together before multiplying, never touches the zero-valued odd taps, and applies the centre tap on its own. The sum is then scaled down by a power of two, rounded and clipped to the output width.

A synchronous clear empties both delay lines and restarts both decimation phases, so filtering can be realigned to an external sync event.

Top module: `halfband_decim4`

## Requirements
- R1: Section one forms y = 3(t0+t10) - 25(t2+t8) + 150(t4+t6) + 256 t5. Here t0 is the sample just accepted and tk is the sample accepted k strobes earlier. Its result is (y + 256) >>> 9, an arithmetic floor shift that rounds half up, then clipped to the signed OW-bit range.
- R2: Section two takes the results of section one as its samples u. It forms z = -10944(u0+u14) + 103807(u2+u12) - 507903(u4+u10) + 2512192(u6+u8) + 4194304 u7. Its result is (z + 4194304) >>> 23, clipped to the signed OW-bit range, and this is the value presented on out_data.
- R3: Section one produces a result on its k-th accepted sample exactly when k is even and k >= 11. Section two does the same on its j-th input when j is even and j >= 15. Counting from reset or clear, the block output therefore appears on accepted input 42, then 46, 50 and so on.
- R4: out_valid is high in the cycle that follows the second rising clock edge after the triggering sample is presented with in_valid high, counting the edge that accepts it.
- R5: A cycle with in_valid low changes no filter state, whatever in_data holds.
- R6: A cycle with clr high empties both delay lines, restarts both phase and fill counts, and drops any result in flight. An in_valid asserted in the same cycle is discarded. out_valid is low in the following cycle.
- R7: After reset, out_valid is low and out_data is zero.
- R8: out_data changes only in a cycle where out_valid is high. Between strobes it keeps the last result.
- R9: A result beyond the signed OW-bit range is clipped to the nearest limit in either section.
- R10: out_valid is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of delay lines and phases |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IW | Signed input sample |
| out_valid | output | 1 | Output sample strobe, one cycle |
| out_data | output | OW | Signed decimated output sample |

## Verification
Three kinds of internal fault show up at the ports in different ways. A tap wired to the wrong delay stage, or a coefficient with a wrong sign, changes the value of the very first output on accepted input 42. An impulse placed at each of the four input phases isolates every coefficient within about sixty samples. A phase or fill counter that is off by one moves the strobe to input 40, 41 or 43, or shifts every later strobe by one accepted sample. That is visible as a strobe with no expected value, or an expected value left unclaimed. A clear that leaves stale samples behind corrupts the first output after the restart, while a missing clipping stage wraps full-scale inputs to the opposite sign within a few hundred samples of random full-scale stimulus.

// File: rtl/halfband_decim4.sv
module halfband_decim4 #(
  parameter int IW = 24,
  parameter int OW = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 in_valid,
  input  logic signed [IW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);

  localparam int N1  = 11;
  localparam int N2  = 15;
  localparam int SH1 = 9;
  localparam int SH2 = 23;
  localparam int AW1 = ((IW > OW) ? IW : OW) + 12;
  localparam int AW2 = OW + 26;
  localparam int CW1 = $clog2(N1);
  localparam int CW2 = $clog2(N2);
  localparam logic signed [AW1-1:0] HI1 = {{(AW1-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [AW1-1:0] LO1 = ~HI1;
  localparam logic signed [AW2-1:0] HI2 = {{(AW2-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [AW2-1:0] LO2 = ~HI2;

  logic signed [IW-1:0]  d1 [N1-1];
  logic        [CW1-1:0] n1;
  logic                  ph1;
  logic signed [AW1-1:0] acc1, rnd1;
  logic signed [OW-1:0]  sat1, q1;
  logic                  v1;

  logic signed [OW-1:0]  d2 [N2-1];
  logic        [CW2-1:0] n2;
  logic                  ph2;
  logic signed [AW2-1:0] acc2, rnd2;
  logic signed [OW-1:0]  sat2;

  wire fire1 = in_valid && ph1 && (n1 == CW1'(N1-1));
  wire fire2 = v1 && ph2 && (n2 == CW2'(N2-1));

  assign acc1 = AW1'(3)   * (AW1'(in_data) + AW1'(d1[9]))
              - AW1'(25)  * (AW1'(d1[1])   + AW1'(d1[7]))
              + AW1'(150) * (AW1'(d1[3])   + AW1'(d1[5]))
              + AW1'(256) *  AW1'(d1[4]);
  assign rnd1 = (acc1 + (AW1'(1) <<< (SH1-1))) >>> SH1;
  assign sat1 = (rnd1 > HI1) ? HI1[OW-1:0] : (rnd1 < LO1) ? LO1[OW-1:0] : rnd1[OW-1:0];

  assign acc2 = AW2'(4194304) *  AW2'(d2[6])
              - AW2'(10944)   * (AW2'(q1)    + AW2'(d2[13]))
              + AW2'(103807)  * (AW2'(d2[1]) + AW2'(d2[11]))
              - AW2'(507903)  * (AW2'(d2[3]) + AW2'(d2[9]))
              + AW2'(2512192) * (AW2'(d2[5]) + AW2'(d2[7]));
  assign rnd2 = (acc2 + (AW2'(1) <<< (SH2-1))) >>> SH2;
  assign sat2 = (rnd2 > HI2) ? HI2[OW-1:0] : (rnd2 < LO2) ? LO2[OW-1:0] : rnd2[OW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N1-1; i++) d1[i] <= '0;
      n1  <= '0;
      ph1 <= 1'b0;
      v1  <= 1'b0;
      q1  <= '0;
    end else if (clr) begin
      for (int i = 0; i < N1-1; i++) d1[i] <= '0;
      n1  <= '0;
      ph1 <= 1'b0;
      v1  <= 1'b0;
    end else begin
      v1 <= fire1;
      if (fire1) q1 <= sat1;
      if (in_valid) begin
        d1[0] <= in_data;
        for (int i = 1; i < N1-1; i++) d1[i] <= d1[i-1];
        ph1 <= ~ph1;
        if (n1 != CW1'(N1-1)) n1 <= n1 + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N2-1; i++) d2[i] <= '0;
      n2        <= '0;
      ph2       <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (clr) begin
      for (int i = 0; i < N2-1; i++) d2[i] <= '0;
      n2        <= '0;
      ph2       <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= fire2;
      if (fire2) out_data <= sat2;
      if (v1) begin
        d2[0] <= q1;
        for (int i = 1; i < N2-1; i++) d2[i] <= d2[i-1];
        ph2 <= ~ph2;
        if (n2 != CW2'(N2-1)) n2 <= n2 + 1'b1;
      end
    end
  end

endmodule

module halfband_decim4_chk #(
  parameter int OW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          in_valid,
  input logic          s1_valid,
  input logic          out_valid,
  input logic [OW-1:0] out_data
);

  assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_half_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> !s1_valid);

  assert_clear_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!out_valid && !s1_valid));

  assert_out_from_s1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(s1_valid));

  assert_s1_from_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> $past(in_valid && !clr));

  assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

endmodule

bind halfband_decim4 halfband_decim4_chk #(.OW(OW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr      (clr),
  .in_valid (in_valid),
  .s1_valid (v1),
  .out_valid(out_valid),
  .out_data (out_data)
);

// File: tb/sim_halfband_decim4.sv
module sim_halfband_decim4;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 16;
  localparam longint OMAX = (64'sd1 <<< (BW-1)) - 1;
  localparam longint OMIN = -(64'sd1 <<< (BW-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic in_valid = 1'b0;
  logic signed [BW-1:0] in_data = '0;
  logic out_valid;
  logic signed [BW-1:0] out_data;

  halfband_decim4 #(.IW(BW), .OW(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int k1 = 0;
  int k2 = 0;
  int clips = 0;
  longint h1 [11];
  longint h2 [15];
  longint exp_q [$];
  int     due_q [$];
  longint last_out = 0;
  logic [31:0] seed = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    total++; bad++;
    $display("FAIL watchdog: R3 run did not end, actual cycle=%0d expected below 150000", cyc);
    report();
  end

  function automatic void step_seed();
    seed = seed * 32'd1103515245 + 32'd12345;
  endfunction

  function automatic longint rs(longint y, int sh);
    longint r;
    r = (y + (64'sd1 <<< (sh-1))) >>> sh;
    if (r > OMAX) begin clips++; r = OMAX; end
    if (r < OMIN) begin clips++; r = OMIN; end
    return r;
  endfunction

  function automatic void model_clear();
    foreach (h1[i]) h1[i] = 0;
    foreach (h2[i]) h2[i] = 0;
    k1 = 0; k2 = 0;
  endfunction

  // R1, R2, R3: reference arithmetic and decimation phase
  function automatic void model_accept(longint x, int c);
    longint y, z, u;
    for (int i = 10; i > 0; i--) h1[i] = h1[i-1];
    h1[0] = x; k1++;
    if (k1 >= 11 && k1 % 2 == 0) begin
      y = 3*(h1[0]+h1[10]) - 25*(h1[2]+h1[8]) + 150*(h1[4]+h1[6]) + 256*h1[5];
      u = rs(y, 9);
      for (int i = 14; i > 0; i--) h2[i] = h2[i-1];
      h2[0] = u; k2++;
      if (k2 >= 15 && k2 % 2 == 0) begin
        z = -10944*(h2[0]+h2[14]) + 103807*(h2[2]+h2[12]) - 507903*(h2[4]+h2[10])
            + 2512192*(h2[6]+h2[8]) + 4194304*h2[7];
        exp_q.push_back(rs(z, 23));
        due_q.push_back(c + 1);
      end
    end
  endfunction

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R3 strobe with no expected sample: actual=%0d expected=none", out_data);
      end else begin
        longint e; int d;
        e = exp_q.pop_front();
        d = due_q.pop_front();
        if (longint'(out_data) != e) begin
          bad++;
          $display("FAIL R1/R2/R9 output value: actual=%0d expected=%0d", out_data, e);
        end
        total++;
        if (cyc != d) begin
          bad++;
          $display("FAIL R4 strobe cycle: actual=%0d expected=%0d", cyc, d);
        end
      end
      last_out = longint'(out_data);
    end else begin
      total++;
      if (longint'(out_data) != last_out) begin
        bad++;
        $display("FAIL R8 hold between strobes: actual=%0d expected=%0d", out_data, last_out);
      end
    end
  end

  task automatic push(input longint x, input bit v);
    @(negedge clk);
    in_valid = v;
    in_data = v ? BW'(x) : BW'(seed[15:0]);
    @(posedge clk);
    #1;
    if (v) model_accept(x, cyc);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      step_seed();
      push(0, 1'b0);
    end
  endtask

  // R6: clear with in_valid asserted in the same cycle
  task automatic do_clear();
    idle(6);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R3 outputs missing before clear: actual=%0d expected=0", exp_q.size());
      exp_q.delete(); due_q.delete();
    end
    @(negedge clk);
    clr = 1'b1; in_valid = 1'b1; in_data = 16'sh7abc;
    @(posedge clk);
    #1;
    clr = 1'b0; in_valid = 1'b0;
    model_clear();
  endtask

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (out_valid !== 1'b0) begin bad++; $display("FAIL R7 out_valid in reset: actual=%b expected=0", out_valid); end
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (out_data !== '0) begin bad++; $display("FAIL R7 out_data after reset: actual=%0d expected=0", out_data); end

    // R1/R2: impulse at each of four input phases
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < p; i++) push(0, 1'b1);
      push(16000, 1'b1);
      for (int i = 0; i < 70; i++) push(0, 1'b1);
      do_clear();
      for (int i = 0; i < 70; i++) push((i == 3 + p) ? -16000 : 0, 1'b1);
      do_clear();
    end

    // R1/R2: DC steps of both signs
    for (int i = 0; i < 80; i++) push(12345, 1'b1);
    for (int i = 0; i < 80; i++) push(-20000, 1'b1);
    do_clear();

    // R5: sparse strobes with garbage data in idle cycles
    for (int i = 0; i < 800; i++) begin
      step_seed();
      if (seed[20]) push(longint'($signed(seed[27:12])), 1'b1);
      else push(0, 1'b0);
    end
    do_clear();

    // R6: clear in mid stream, then restart from a clean phase
    for (int i = 0; i < 30; i++) push(longint'(i * 977 - 9000), 1'b1);
    do_clear();
    for (int i = 0; i < 90; i++) push(longint'(i * 311 - 13000), 1'b1);
    do_clear();

    // R9: random full-scale stimulus drives clipping
    for (int i = 0; i < 3000; i++) begin
      step_seed();
      push(seed[17] ? OMAX : OMIN, 1'b1);
    end
    do_clear();

    // Near-exhaustive sweep of small amplitudes and alternation
    for (int v = -128; v < 128; v++) push(longint'(v), 1'b1);
    for (int i = 0; i < 256; i++) push((i % 2) ? longint'(i * 64) : -longint'(i * 64), 1'b1);
    idle(8);

    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R3 outputs missing at end: actual=%0d expected=0", exp_q.size());
    end
    total++;
    if (clips == 0) begin
      bad++;
      $display("FAIL R9 clipping never exercised: actual=%0d expected=nonzero", clips);
    end
    report();
  end
endmodule